// File: doc/BRIEF.md
# Single-Line Dirty-Line Eviction Buffer

This block parks one dirty cache line that the cache controller is evicting, so that the line fill which caused the eviction can use the external bus first. The controller hands over a 16-byte line and bits 31..4 of its physical address in a single cycle. The buffer then holds the line until the controller reports that its fill has finished. After that, it writes the line to memory as four 32-bit beats.

The external bus is shared through a fixed-priority arbiter, and fills always win it. A write beat that is already on the bus runs until it is acknowledged. A fill that arrives between beats then takes the bus, and draining continues when the fill releases it. While the line is held, the block raises a busy flag. The controller uses this flag to stall the next dirty eviction, and it keeps serving CPU accesses in the meantime.

Top module: `wbb_top`

## Requirements
- R1: A cycle with `evict_valid` high while `evict_busy` is low captures `evict_line` (physical address bits 31..4) and `evict_data`, where longword k is `evict_data[32k+31:32k]`. `evict_busy` reads 1 from the next cycle.
- R2: No memory write is issued while the buffer is holding a line and `fill_done` has not yet been seen for it.
- R3: After `fill_done`, the held line is written as exactly four beats in the order longword 0, 1, 2, 3. Each beat has `mem_we`=1, `mem_addr` = {line bits 31..4, k[1:0], 2'b00} and `mem_wdata` = longword k. Address and data stay stable until `mem_ack`.
- R4: `evict_busy` stays 1 up to and including the cycle in which the fourth beat is acknowledged, and reads 0 in the following cycle.
- R5: `evict_valid` while `evict_busy` is 1 is ignored, and the held line's contents are unchanged.
- R6: When the bus is idle and both a fill request and a pending write beat want it, the fill is granted (`fill_gnt`=1) first.
- R7: A fill request that arrives during a write beat does not cut the beat short. The fill is granted before the next beat, and draining resumes after `fill_req` falls.
- R8: While the fill is granted, the bus carries a read (`mem_we`=0) at `fill_addr`, and `mem_req` follows `fill_req`.
- R9: After reset, `evict_busy`, `mem_req` and `fill_gnt` are 0.
- R10: A `fill_done` pulse while the buffer is empty, or while it is already draining, has no effect: a line captured later still waits for its own `fill_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | Hand over a dirty line this cycle |
| evict_line | input | 28 | Physical address bits 31..4 of the line |
| evict_data | input | 128 | Line data, longword k at bits 32k+31..32k |
| evict_busy | output | 1 | Buffer holds a line; new evictions must stall |
| fill_done | input | 1 | Pulse: the controller's line fill has finished |
| fill_req | input | 1 | Controller wants the bus for a fill |
| fill_addr | input | 32 | Address of the current fill read |
| fill_gnt | output | 1 | Bus is granted to the fill |
| mem_req | output | 1 | Bus cycle request, held until acknowledged |
| mem_we | output | 1 | 1 for a write-back beat, 0 for a fill read |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Write data for write-back beats |
| mem_ack | input | 1 | Memory acknowledges the current cycle |

## Verification
A stuck or mistimed "waiting for fill" flag shows up at the ports in one of two ways: writes appear on the bus before `fill_done`, or no writes ever appear and `evict_busy` never falls. Both are visible within a few cycles of the pulse. A beat counter that is off by one shows up on the very first write, as a wrong address bit 2 or 3 with mismatched data. A full flag that clears early or late moves the falling edge of `evict_busy` away from the cycle after the fourth acknowledge. An arbiter that ignores priority shows up as a write beat where the fill read should have started.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_FILL = 2'd1,
    OWN_WB   = 2'd2
  } bus_own_e;
endpackage

// File: rtl/wbb_line.sv
// Line store with full / waiting-for-fill flags.
module wbb_line #(
  parameter int LINE_AW = 28,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [LINE_AW-1:0] line_addr_i,
  input  logic [LINE_W-1:0]  line_data_i,
  input  logic               fill_done_i,
  input  logic               last_ack_i,
  output logic               full_o,
  output logic               pend_o,
  output logic [LINE_AW-1:0] addr_o,
  output logic [LINE_W-1:0]  data_o
);
  logic take;
  assign take = load_i && !full_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      pend_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      if (take) begin
        full_o <= 1'b1;
        pend_o <= 1'b1;
        addr_o <= line_addr_i;
        data_o <= line_data_i;
      end else begin
        if (fill_done_i && pend_o) pend_o <= 1'b0;
        if (last_ack_i) full_o <= 1'b0;
      end
    end
  end

  AST_PEND_IMPLIES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> full_o);  // R2
  AST_HELD_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && $past(full_o) && !$past(take)) |-> ($stable(addr_o) && $stable(data_o)));  // R5
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (full_o && pend_o));  // R1
endmodule

// File: rtl/wbb_beat.sv
// Longword index counter for the drain sequence.
module wbb_beat #(
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  assign last_o = (idx_o == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) idx_o <= '0;
    else if (adv_i) idx_o <= last_o ? '0 : idx_o + 1'b1;
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !last_o) |=> (idx_o == $past(idx_o) + 1'b1));  // R3
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && last_o) |=> (idx_o == '0));  // R4
endmodule

// File: rtl/wbb_arb.sv
// Fixed-priority bus owner: fill beats write-back, a granted write beat runs to its ack.
module wbb_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_req_i,
  input  logic wb_want_i,
  input  logic mem_ack_i,
  output logic fill_gnt_o,
  output logic wb_gnt_o
);
  import wbb_pkg::*;

  bus_own_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_IDLE: begin
        if (fill_req_i)     own_d = OWN_FILL;
        else if (wb_want_i) own_d = OWN_WB;
      end
      OWN_FILL: if (!fill_req_i) own_d = OWN_IDLE;
      OWN_WB:   if (mem_ack_i)   own_d = OWN_IDLE;
      default:  own_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) own_q <= OWN_IDLE;
    else        own_q <= own_d;
  end

  assign fill_gnt_o = (own_q == OWN_FILL);
  assign wb_gnt_o   = (own_q == OWN_WB);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_gnt_o, wb_gnt_o}));  // R6
  AST_FILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_gnt_o && !wb_gnt_o && fill_req_i) |=> fill_gnt_o);  // R6
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_gnt_o && !mem_ack_i) |=> wb_gnt_o);  // R7
endmodule

// File: rtl/wbb_top.sv
module wbb_top #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int LINE_W   = WORD_W * WORDS,
  localparam int BYTE_OFF = $clog2(WORD_W / 8),
  localparam int IDX_W    = $clog2(WORDS),
  localparam int LINE_AW  = ADDR_W - BYTE_OFF - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evict_valid,
  input  logic [LINE_AW-1:0] evict_line,
  input  logic [LINE_W-1:0]  evict_data,
  output logic               evict_busy,
  input  logic               fill_done,
  input  logic               fill_req,
  input  logic [ADDR_W-1:0]  fill_addr,
  output logic               fill_gnt,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_ack
);
  // Address of longword idx within a line.
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [LINE_AW-1:0] line,
                                                  input logic [IDX_W-1:0] idx);
    return {line, idx, {BYTE_OFF{1'b0}}};
  endfunction

  logic               full, pend, wb_gnt, wb_want, wb_ack, last_beat, last_ack;
  logic [IDX_W-1:0]   idx;
  logic [LINE_AW-1:0] held_line;
  logic [LINE_W-1:0]  held_data;
  logic [WORD_W-1:0]  lw [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_lw
    assign lw[k] = held_data[k*WORD_W +: WORD_W];
  end

  assign wb_want  = full && !pend;
  assign wb_ack   = wb_gnt && mem_ack;
  assign last_ack = wb_ack && last_beat;

  wbb_line #(.LINE_AW(LINE_AW), .WORD_W(WORD_W), .WORDS(WORDS)) u_line (
    .clk(clk), .rst_n(rst_n), .load_i(evict_valid), .line_addr_i(evict_line),
    .line_data_i(evict_data), .fill_done_i(fill_done), .last_ack_i(last_ack),
    .full_o(full), .pend_o(pend), .addr_o(held_line), .data_o(held_data)
  );

  wbb_beat #(.WORDS(WORDS)) u_beat (
    .clk(clk), .rst_n(rst_n), .adv_i(wb_ack), .idx_o(idx), .last_o(last_beat)
  );

  wbb_arb u_arb (
    .clk(clk), .rst_n(rst_n), .fill_req_i(fill_req), .wb_want_i(wb_want),
    .mem_ack_i(mem_ack), .fill_gnt_o(fill_gnt), .wb_gnt_o(wb_gnt)
  );

  assign evict_busy = full;
  assign mem_req    = wb_gnt || (fill_gnt && fill_req);
  assign mem_we     = wb_gnt;
  assign mem_addr   = wb_gnt ? beat_addr(held_line, idx) : fill_addr;
  assign mem_wdata  = wb_gnt ? lw[idx] : '0;

  AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !mem_we);  // R2
  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));  // R3
  AST_BUSY_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_busy && !last_ack) |=> evict_busy);  // R4
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    last_ack |=> !evict_busy);  // R4
  AST_FILL_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fill_gnt |-> (!mem_we && mem_addr == fill_addr));  // R8
  AST_WRITE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> evict_busy);  // R10
endmodule

// File: tb/sim_wbb_top.sv
module sim_wbb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         evict_valid = 0;
  logic [27:0]  evict_line = '0;
  logic [127:0] evict_data = '0;
  logic         evict_busy;
  logic         fill_done = 0;
  logic         fill_req = 0;
  logic [31:0]  fill_addr = '0;
  logic         fill_gnt;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic         mem_ack = 0;

  always #2 clk = ~clk;  // 250 MHz

  wbb_top u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  int wr_total = 0, fill_beats = 0, fill_start_wr = -1, lat_cnt = 0;
  bit chk_clear = 0;
  localparam int LAT = 2;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model and monitor: decides the ack at the falling edge, compares then.
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_clear) begin
        chk_clear = 0;
        chk(!evict_busy, "R4 busy low after last ack", 64'(evict_busy), 64'd0);
      end
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        lat_cnt++;
        if (lat_cnt >= LAT) begin
          lat_cnt = 0;
          mem_ack = 1;
          if (mem_we) begin
            wr_total++;
            if (exp_q.size() == 0)
              chk(0, "R3 unexpected write", {mem_addr, mem_wdata}, 64'd0);
            else begin
              logic [63:0] e;
              e = exp_q.pop_front();
              chk({mem_addr, mem_wdata} == e, "R3 write beat", {mem_addr, mem_wdata}, e);
              if (exp_q.size() == 0) begin
                chk(evict_busy, "R4 busy high during last beat", 64'(evict_busy), 64'd1);
                chk_clear = 1;
              end
            end
          end else begin
            if (fill_beats == 0) fill_start_wr = wr_total;
            fill_beats++;
            chk(fill_gnt && mem_addr == fill_addr, "R8 fill read", {31'd0, fill_gnt, mem_addr},
                {32'd1, fill_addr});
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic evict(input logic [27:0] line, input logic [127:0] data, input bit expect_take);
    @(negedge clk); #1;
    evict_valid = 1; evict_line = line; evict_data = data;
    if (expect_take)
      for (int k = 0; k < 4; k++)
        exp_q.push_back({line, 2'(k), 2'b00, data[32*k +: 32]});
    tick(1);
    evict_valid = 0;
  endtask

  task automatic pulse_done();
    fill_done = 1; tick(1); fill_done = 0;
  endtask

  task automatic run_fill(input logic [31:0] a);
    fill_beats = 0; fill_start_wr = -1;
    fill_req = 1; fill_addr = a;
    for (int i = 0; i < 100 && fill_beats < 4; i++) tick(1);
    tick(1);
    fill_req = 0;
  endtask

  task automatic wait_drain(input string tag);
    for (int i = 0; i < 200 && (evict_busy || exp_q.size() != 0); i++) tick(1);
    tick(2);
    chk(!evict_busy && exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    int w0;
    tick(3);
    chk(!evict_busy && !mem_req && !fill_gnt, "R9 reset outputs",
        {61'd0, evict_busy, mem_req, fill_gnt}, 64'd0);
    rst_n = 1;
    tick(1);

    // R1 / R5 / R2 / R3 / R4: basic eviction with a blocked second eviction
    evict(28'hA5A5A5A, 128'h33333333_22222222_11111111_00000000, 1);
    chk(evict_busy, "R1 busy after capture", 64'(evict_busy), 64'd1);
    evict(28'h1234567, 128'hDEADDEAD_BEEFBEEF_CAFECAFE_F00DF00D, 0);
    tick(10);
    chk(wr_total == 0, "R2 no write before fill_done", 64'(wr_total), 64'd0);
    chk(evict_busy, "R5 still busy, line held", 64'(evict_busy), 64'd1);
    pulse_done();
    wait_drain("R3 first line drained");
    chk(wr_total == 4, "R5 only four writes for ignored eviction", 64'(wr_total), 64'd4);

    // R10: stray fill_done with empty buffer
    pulse_done();
    tick(2);
    evict(28'h0F0F0F0, 128'h44444444_55555555_66666666_77777777, 1);
    tick(10);
    chk(wr_total == 4, "R10 stray fill_done ignored", 64'(wr_total), 64'd4);
    pulse_done();
    wait_drain("R10 drained after real fill_done");

    // R6: fill and pending beat collide on an idle bus
    evict(28'h8000001, 128'h89ABCDEF_01234567_FEDCBA98_76543210, 1);
    w0 = wr_total;
    pulse_done();
    run_fill(32'h0000_1230);
    chk(fill_start_wr == w0, "R6 fill before first write", 64'(fill_start_wr), 64'(w0));
    chk(fill_beats == 4, "R8 four fill reads", 64'(fill_beats), 64'd4);
    wait_drain("R6 drain resumes after fill");

    // R7: fill arrives during an in-flight write beat; R10: fill_done while draining
    evict(28'h7654321, 128'hAAAA0003_AAAA0002_AAAA0001_AAAA0000, 1);
    pulse_done();
    for (int i = 0; i < 50 && !(mem_req && mem_we && !mem_ack); i++) tick(1);
    w0 = wr_total;
    pulse_done();
    run_fill(32'h0000_4560);
    chk(fill_start_wr == w0 + 1, "R7 current beat finished before fill", 64'(fill_start_wr),
        64'(w0 + 1));
    wait_drain("R7 drain resumes");
    chk(wr_total == w0 + 4, "R7 four writes total", 64'(wr_total), 64'(w0 + 4));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule